// File: doc/BRIEF.md
# SD Card Single-Line Write Data Receiver

This block sits on the card side of a one-bit SD data line during host writes. Once a write command has been accepted, it watches the line for a start bit. It then shifts in a block of the configured length, followed by a 16-bit CRC and an end bit, and checks both. After a fixed two-clock turnaround it drives a five-bit status token back to the host. Blocks that pass the check and whose token went out in full are placed in one of two block slots. A valid/ready stream offers those slots to the programming logic.

The programming logic accepts one block at a time through `pg_valid`/`pg_ready`. It reports completion with a one-cycle `pg_done` pulse, and raises `pg_err` in that same cycle if programming failed. While a write is open and both slots are taken, the receiver pulls the line low as a busy signal. A stop command ends the open write, and the receiver's response depends on which phase it interrupts. After a stop, busy stays asserted until every slot has been programmed. Deselecting the card silences the line. Reselecting it brings busy back if work remains.

Top module: `sdw_write_rx`

## Requirements
- R1: After reset the card does not drive the line (`dat_oe` low) and `pg_valid` is low.
- R2: The two clocks that follow the sampled end bit are released (line reads 1). The next five clocks carry the token, MSB first: 0, three status bits, 1.
- R3: A block whose CRC-16 (polynomial 0x1021, initial value 0, data MSB first, CRC MSB first) matches and whose end bit is 1 is answered with status 010. It is offered on `pg_data` with the first received bit in the MSB.
- R4: A CRC mismatch or an end bit of 0 is answered with status 101, and the block is never offered.
- R5: While a write is open, the card is selected and both slots are occupied (queued or being programmed), the line is driven low. It is released in the cycle after the `pg_done` that frees a slot.
- R6: `pg_valid` is high only when a slot is queued and no block is being programmed. While `pg_ready` is low, `pg_valid` and `pg_data` hold.
- R7: After a `pg_done` with `pg_err` high, further blocks get no token (the line reads 1 in all token clocks) and are not offered. A new write start clears this condition.
- R8: A stop sampled during data, CRC, end bit or turnaround discards the block. The line is released for four clocks, after which busy is driven while any slot is occupied.
- R9: A stop sampled in any token clock, including the token end bit, discards the block. A stop one clock later keeps it.
- R10: A stop between blocks closes the write: busy is driven while any slot is occupied, and start bits are ignored until the next write start.
- R11: While `sel` is low the line is never driven. Raising `sel` again restores busy if slots are still occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; the line is sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Card is selected |
| wr_start | input | 1 | One-cycle pulse: a write command was accepted |
| stop_req | input | 1 | One-cycle pulse: stop command end bit seen this cycle |
| dat_in | input | 1 | Sampled value of the data line |
| dat_oe | output | 1 | Card drives the data line |
| dat_out | output | 1 | Value driven when `dat_oe` is high |
| pg_valid | output | 1 | A block is offered for programming |
| pg_ready | input | 1 | Programming logic accepts the offered block |
| pg_data | output | BLK_BYTES*8 | Offered block, first received bit in the MSB |
| pg_done | input | 1 | One-cycle pulse: programming of the accepted block ended |
| pg_err | input | 1 | Qualifies `pg_done`: programming failed |

## Verification
The stop command and the end of the status token can land on the same clock. That collision decides whether a block is committed. The bench raises the stop on the token's final clock and also one clock later. It judges the outcome from `pg_valid` and from whether busy appears on the line. A second overlap is the slot release by `pg_done` against the busy hold. There, the released line is expected on exactly the clock after the done pulse.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_CRC,
    ST_END,
    ST_TURN,
    ST_TOK,
    ST_TAIL
  } rx_state_t;

  localparam logic [15:0] CRC16_POLY = 16'h1021;

  // one serial step of the data CRC, MSB-first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC16_POLY : 16'h0000);
  endfunction

endpackage

// File: rtl/sdw_crc16.sv
module sdw_crc16 (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic bit_in,
  output logic zero
);
  import sdw_pkg::*;

  logic [15:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc_q <= '0;
    else if (en)       crc_q <= crc16_step(crc_q, bit_in);
  end

  // remainder over data plus received CRC is zero when they match
  assign zero = (crc_q == 16'h0000);

endmodule

// File: rtl/sdw_blk_queue.sv
module sdw_blk_queue #(
  parameter int BLK_BITS = 128,
  parameter int NSLOT    = 2,
  parameter int OCC_W    = $clog2(NSLOT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [BLK_BITS-1:0] push_data,
  output logic                pg_valid,
  input  logic                pg_ready,
  output logic [BLK_BITS-1:0] pg_data,
  input  logic                pg_done,
  output logic [OCC_W-1:0]    occ
);
  localparam int PTR_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NSLOT - 1);

  logic [PTR_W-1:0]    wr_ptr, rd_ptr;
  logic [OCC_W-1:0]    q_cnt;
  logic                inflight;
  logic                accept;
  logic [BLK_BITS-1:0] slot_q [NSLOT];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [BLK_BITS-1:0] q;
    always_ff @(posedge clk) begin
      if (push && (wr_ptr == PTR_W'(g))) q <= push_data;
    end
    assign slot_q[g] = q;
  end

  assign pg_valid = (q_cnt != '0) && !inflight;
  assign pg_data  = slot_q[rd_ptr];
  assign accept   = pg_valid && pg_ready;
  assign occ      = q_cnt + OCC_W'(inflight);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      q_cnt    <= '0;
      inflight <= 1'b0;
    end else begin
      if (push)   wr_ptr <= ptr_next(wr_ptr);
      if (accept) rd_ptr <= ptr_next(rd_ptr);
      q_cnt <= q_cnt + OCC_W'(push) - OCC_W'(accept);
      if (accept)       inflight <= 1'b1;
      else if (pg_done) inflight <= 1'b0;
    end
  end

endmodule

// File: rtl/sdw_rx_fsm.sv
module sdw_rx_fsm #(
  parameter int BLK_BITS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                dat_in,
  input  logic                wr_start,
  input  logic                stop_req,
  input  logic                pg_done,
  input  logic                pg_err,
  input  logic                occ_full,
  input  logic                occ_any,
  output logic                dat_oe,
  output logic                dat_out,
  output logic                push,
  output logic [BLK_BITS-1:0] push_data,
  output logic                in_write
);
  import sdw_pkg::*;

  localparam int CNT_W = $clog2((BLK_BITS > 16) ? BLK_BITS : 16);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BLK_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_CRC  = CNT_W'(15);
  localparam logic [CNT_W-1:0] LAST_TURN = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_TOK  = CNT_W'(4);
  localparam logic [CNT_W-1:0] LAST_TAIL = CNT_W'(3);

  rx_state_t           state;
  logic [CNT_W-1:0]    cnt;
  logic [BLK_BITS-1:0] shift_q;
  logic                err_lock, mute_q, good_q;
  logic                start_det, crc_en, crc_zero;
  logic                mute_now, busy_hold, tok_bit, in_frame;

  assign start_det = (state == ST_IDLE) && sel && in_write && !occ_full &&
                     !dat_in && !stop_req;
  assign crc_en    = (state == ST_DATA) || (state == ST_CRC);
  assign in_frame  = (state == ST_DATA) || (state == ST_CRC) || (state == ST_END) ||
                     (state == ST_TURN) || (state == ST_TOK);
  assign mute_now  = mute_q || err_lock;
  assign busy_hold = in_write ? occ_full : occ_any;

  sdw_crc16 u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start_det),
    .en     (crc_en),
    .bit_in (dat_in),
    .zero   (crc_zero)
  );

  always_comb begin
    unique case (cnt[2:0])
      3'd0:    tok_bit = 1'b0;
      3'd1:    tok_bit = !good_q;
      3'd2:    tok_bit = good_q;
      3'd3:    tok_bit = !good_q;
      default: tok_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      in_write <= 1'b0;
      err_lock <= 1'b0;
      mute_q   <= 1'b0;
      good_q   <= 1'b0;
      shift_q  <= '0;
    end else begin
      if (wr_start)      in_write <= 1'b1;
      else if (stop_req) in_write <= 1'b0;

      if (wr_start)                err_lock <= 1'b0;
      else if (pg_done && pg_err)  err_lock <= 1'b1;

      if (stop_req && in_frame) begin
        state <= ST_TAIL;
        cnt   <= '0;
      end else begin
        unique case (state)
          ST_IDLE: if (start_det) begin
            state  <= ST_DATA;
            cnt    <= '0;
            mute_q <= err_lock;
          end
          ST_DATA: begin
            shift_q <= {shift_q[BLK_BITS-2:0], dat_in};
            if (cnt == LAST_DATA) begin state <= ST_CRC; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          ST_CRC:
            if (cnt == LAST_CRC) begin state <= ST_END; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          ST_END: begin
            good_q <= crc_zero && dat_in;
            state  <= ST_TURN;
            cnt    <= '0;
          end
          ST_TURN:
            if (cnt == LAST_TURN) begin state <= ST_TOK; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          ST_TOK:
            if (cnt == LAST_TOK) begin state <= ST_IDLE; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          ST_TAIL:
            if (cnt == LAST_TAIL) begin state <= ST_IDLE; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          default: begin state <= ST_IDLE; cnt <= '0; end
        endcase
      end
    end
  end

  // commit only once the last token clock completes without a stop
  assign push      = (state == ST_TOK) && (cnt == LAST_TOK) && !stop_req &&
                     good_q && !mute_now;
  assign push_data = shift_q;

  assign dat_oe  = sel && (((state == ST_TOK) && !mute_now) ||
                           ((state == ST_IDLE) && busy_hold));
  assign dat_out = (state == ST_TOK) ? tok_bit : 1'b0;

endmodule

// File: rtl/sdw_write_rx.sv
module sdw_write_rx #(
  parameter  int BLK_BYTES = 16,
  parameter  int NSLOT     = 2,
  localparam int BLK_BITS  = BLK_BYTES * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                wr_start,
  input  logic                stop_req,
  input  logic                dat_in,
  output logic                dat_oe,
  output logic                dat_out,
  output logic                pg_valid,
  input  logic                pg_ready,
  output logic [BLK_BITS-1:0] pg_data,
  input  logic                pg_done,
  input  logic                pg_err
);
  localparam int OCC_W = $clog2(NSLOT + 1);

  logic [OCC_W-1:0]    occ;
  logic                push, in_write, occ_full, occ_any;
  logic [BLK_BITS-1:0] push_data;

  assign occ_full = (occ == OCC_W'(NSLOT));
  assign occ_any  = (occ != '0);

  sdw_rx_fsm #(.BLK_BITS(BLK_BITS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .dat_in    (dat_in),
    .wr_start  (wr_start),
    .stop_req  (stop_req),
    .pg_done   (pg_done),
    .pg_err    (pg_err),
    .occ_full  (occ_full),
    .occ_any   (occ_any),
    .dat_oe    (dat_oe),
    .dat_out   (dat_out),
    .push      (push),
    .push_data (push_data),
    .in_write  (in_write)
  );

  sdw_blk_queue #(.BLK_BITS(BLK_BITS), .NSLOT(NSLOT), .OCC_W(OCC_W)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pg_valid  (pg_valid),
    .pg_ready  (pg_ready),
    .pg_data   (pg_data),
    .pg_done   (pg_done),
    .occ       (occ)
  );

endmodule

// File: rtl/sdw_write_rx_chk.sv
module sdw_write_rx_chk #(
  parameter int BLK_BITS = 128,
  parameter int NSLOT    = 2,
  parameter int OCC_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sel,
  input logic                dat_oe,
  input logic                dat_out,
  input logic                pg_valid,
  input logic                pg_ready,
  input logic [BLK_BITS-1:0] pg_data,
  input logic                in_write,
  input logic [OCC_W-1:0]    occ,
  input logic                push
);

  // R5
  full_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_write && sel && (occ == OCC_W'(NSLOT))) |-> (dat_oe && !dat_out));

  // R5
  commit_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (occ < OCC_W'(NSLOT)));

  // R6
  pg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_valid && !pg_ready) |=> (pg_valid && $stable(pg_data)));

  // R6
  one_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_valid && pg_ready) |=> !pg_valid);

  // R11
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !dat_oe);

endmodule

bind sdw_write_rx sdw_write_rx_chk #(
  .BLK_BITS (BLK_BITS),
  .NSLOT    (NSLOT),
  .OCC_W    (OCC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel      (sel),
  .dat_oe   (dat_oe),
  .dat_out  (dat_out),
  .pg_valid (pg_valid),
  .pg_ready (pg_ready),
  .pg_data  (pg_data),
  .in_write (in_write),
  .occ      (occ),
  .push     (push)
);

// File: tb/sdw_write_rx_tb.sv
module sdw_write_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BLK_BYTES  = 16;
  localparam int BLK_BITS   = BLK_BYTES * 8;
  localparam int FRAME      = BLK_BITS + 27;
  localparam int NVEC       = 6;
  // {seed[7:0], crc_flip, end_bit, expected status[2:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {8'd1, 1'b0, 1'b1, 3'b010},
    {8'd2, 1'b1, 1'b1, 3'b101},
    {8'd3, 1'b0, 1'b0, 3'b101},
    {8'd4, 1'b0, 1'b1, 3'b010},
    {8'd5, 1'b1, 1'b0, 3'b101},
    {8'd6, 1'b0, 1'b1, 3'b010}
  };

  logic clk, rst_n, sel, wr_start, stop_req, dat_in;
  logic dat_oe, dat_out, pg_valid, pg_ready, pg_done, pg_err;
  logic [BLK_BITS-1:0] pg_data;
  logic obs [FRAME];
  int n_chk, n_fail;
  bit finished;

  sdw_write_rx #(.BLK_BYTES(BLK_BYTES), .NSLOT(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_start(wr_start), .stop_req(stop_req),
    .dat_in(dat_in), .dat_oe(dat_oe), .dat_out(dat_out), .pg_valid(pg_valid),
    .pg_ready(pg_ready), .pg_data(pg_data), .pg_done(pg_done), .pg_err(pg_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic line_now();
    return dat_oe ? dat_out : 1'b1;
  endfunction

  function automatic logic [BLK_BITS-1:0] payload(input int seed);
    logic [BLK_BITS-1:0] d;
    for (int i = 0; i < BLK_BITS / 32; i++)
      d[i*32 +: 32] = (seed * (i + 1)) * 32'h9E3779B1 + i;
    return d;
  endfunction

  function automatic logic [15:0] crc_of(input logic [BLK_BITS-1:0] d);
    logic [15:0] c = '0;
    for (int i = BLK_BITS - 1; i >= 0; i--)
      c = {c[14:0], 1'b0} ^ ((c[15] ^ d[i]) ? 16'h1021 : 16'h0000);
    return c;
  endfunction

  function automatic logic [6:0] tok7();
    logic [6:0] t;
    for (int k = 0; k < 7; k++) t[6-k] = obs[BLK_BITS + 18 + k];
    return t;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [BLK_BITS-1:0] act, input logic [BLK_BITS-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wr();
    @(negedge clk) wr_start = 1'b1;
    @(negedge clk) wr_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
  endtask

  // obs[i] is the card's line value in the clock where frame bit i is driven
  task automatic send_block(input logic [BLK_BITS-1:0] d, input bit flip,
                            input bit endb, input int stop_at);
    logic [15:0] c;
    logic b;
    c = crc_of(d) ^ {15'd0, flip};
    for (int idx = 0; idx < FRAME - 1; idx++) begin
      @(negedge clk);
      obs[idx] = line_now();
      if (idx == 0)                   b = 1'b0;
      else if (idx <= BLK_BITS)       b = d[BLK_BITS - idx];
      else if (idx <= BLK_BITS + 16)  b = c[15 - (idx - BLK_BITS - 1)];
      else if (idx == BLK_BITS + 17)  b = endb;
      else                            b = 1'b1;
      dat_in   = b;
      stop_req = (idx == stop_at);
    end
    @(negedge clk);
    obs[FRAME-1] = line_now();
    dat_in   = 1'b1;
    stop_req = 1'b0;
  endtask

  task automatic prog_one(input logic [BLK_BITS-1:0] exp, input bit err, input string tag);
    for (int w = 0; w < 50 && !pg_valid; w++) @(negedge clk);
    chk(pg_valid === 1'b1, tag, {127'd0, pg_valid}, 1);
    chk(pg_data === exp, tag, pg_data, exp);
    pg_ready = 1'b1;
    @(negedge clk) pg_ready = 1'b0;
    @(negedge clk) begin pg_done = 1'b1; pg_err = err; end
    @(negedge clk) begin pg_done = 1'b0; pg_err = 1'b0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [BLK_BITS-1:0] pa, pb;
    rst_n = 1'b0; sel = 1'b1; wr_start = 1'b0; stop_req = 1'b0; dat_in = 1'b1;
    pg_ready = 1'b0; pg_done = 1'b0; pg_err = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    chk(dat_oe === 1'b0, "R1 oe", {127'd0, dat_oe}, 0);
    chk(pg_valid === 1'b0, "R1 valid", {127'd0, pg_valid}, 0);

    // vector table: R2 turnaround and token, R3 good, R4 bad CRC / end bit
    pulse_wr();
    for (int v = 0; v < NVEC; v++) begin
      pa = payload(int'(VEC[v][12:5]));
      send_block(pa, VEC[v][4], VEC[v][3], -1);
      chk(tok7() === {3'b110, VEC[v][2:0], 1'b1}, "R2 R3 R4 token",
          {121'd0, tok7()}, {121'd0, 3'b110, VEC[v][2:0], 1'b1});
      if (VEC[v][2:0] == 3'b010) prog_one(pa, 1'b0, "R3 data");
      else begin
        tick(2);
        chk(pg_valid === 1'b0, "R4 dropped", {127'd0, pg_valid}, 0);
      end
    end

    // R5 both slots full -> busy; R6 hold under back-pressure
    pa = payload(20); pb = payload(21);
    send_block(pa, 1'b0, 1'b1, -1);
    chk(line_now() === 1'b1, "R5 one slot free", {127'd0, line_now()}, 1);
    send_block(pb, 1'b0, 1'b1, -1);
    chk(line_now() === 1'b0, "R5 busy full", {127'd0, line_now()}, 0);
    tick(6);
    chk(pg_valid === 1'b1 && pg_data === pa, "R6 hold", pg_data, pa);
    prog_one(pa, 1'b0, "R6 data");
    chk(line_now() === 1'b1, "R5 release after done", {127'd0, line_now()}, 1);
    prog_one(pb, 1'b0, "R6 second");
    pulse_stop();

    // R8 stop during data with one block pending
    pulse_wr();
    pa = payload(30); pb = payload(31);
    send_block(pa, 1'b0, 1'b1, -1);
    send_block(pb, 1'b0, 1'b1, 20);
    chk({obs[21], obs[22], obs[23], obs[24], obs[25]} === 5'b11110, "R8 tail then busy",
        {123'd0, obs[21], obs[22], obs[23], obs[24], obs[25]}, 5'b11110);
    prog_one(pa, 1'b0, "R8 pending kept");
    tick(3);
    chk(line_now() === 1'b1, "R8 released", {127'd0, line_now()}, 1);
    chk(pg_valid === 1'b0, "R8 discarded", {127'd0, pg_valid}, 0);

    // R9 stop on the token end bit discards
    pulse_wr();
    pa = payload(40);
    send_block(pa, 1'b0, 1'b1, BLK_BITS + 24);
    tick(6);
    chk(pg_valid === 1'b0, "R9 cut token", {127'd0, pg_valid}, 0);
    chk(line_now() === 1'b1, "R9 no busy", {127'd0, line_now()}, 1);

    // R9/R10 stop one clock later keeps the block, busy until programmed
    pulse_wr();
    pa = payload(41);
    send_block(pa, 1'b0, 1'b1, BLK_BITS + 25);
    chk(obs[FRAME-1] === 1'b0, "R10 busy after stop", {127'd0, obs[FRAME-1]}, 0);
    chk(pg_valid === 1'b1, "R9 kept", {127'd0, pg_valid}, 1);
    prog_one(pa, 1'b0, "R9 data");
    chk(line_now() === 1'b1, "R10 released", {127'd0, line_now()}, 1);
    // R10 start bits ignored with no open write
    send_block(payload(42), 1'b0, 1'b1, -1);
    chk(tok7() === 7'b1111111, "R10 ignored", {121'd0, tok7()}, 7'h7f);
    chk(pg_valid === 1'b0, "R10 none offered", {127'd0, pg_valid}, 0);

    // R7 programming error locks out further blocks
    pulse_wr();
    pa = payload(50);
    send_block(pa, 1'b0, 1'b1, -1);
    prog_one(pa, 1'b1, "R7 first");
    send_block(payload(51), 1'b0, 1'b1, -1);
    chk(tok7() === 7'b1111111, "R7 no token", {121'd0, tok7()}, 7'h7f);
    chk(pg_valid === 1'b0, "R7 not offered", {127'd0, pg_valid}, 0);
    pulse_wr();
    pa = payload(52);
    send_block(pa, 1'b0, 1'b1, -1);
    chk(tok7() === 7'b1100101, "R7 cleared", {121'd0, tok7()}, 7'b1100101);
    prog_one(pa, 1'b0, "R7 data");

    // R11 deselect silences busy, reselect restores it
    pa = payload(60); pb = payload(61);
    send_block(pa, 1'b0, 1'b1, -1);
    send_block(pb, 1'b0, 1'b1, -1);
    @(negedge clk) sel = 1'b0;
    @(negedge clk);
    chk(dat_oe === 1'b0, "R11 deselected", {127'd0, dat_oe}, 0);
    @(negedge clk) sel = 1'b1;
    @(negedge clk);
    chk(line_now() === 1'b0, "R11 reselect busy", {127'd0, line_now()}, 0);
    prog_one(pa, 1'b0, "R11 data");
    prog_one(pb, 1'b0, "R11 data2");
    pulse_stop();
    tick(3);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule